// File: doc/BRIEF.md
# Programmable Counter Array

A shared 16-bit up-counter acts as the timebase for a small array of compare/capture modules, with two modules by default. Each module owns one external pin. The counter takes its count steps from one of four sources. The first two are fixed divisions of the system clock. The third is a one-cycle overflow pulse from a neighbouring timer. The fourth is the falling edge of an external count input, and that input is synchronized first. A run bit starts and stops the counter. An idle-stop option freezes it while the chip reports idle.

Each module has its own configuration register, and it works in one of four ways. It can latch the counter value when its pin has an edge. It can raise a flag when the counter steps onto the module's 16-bit value. It can also toggle its pin on that match. Finally, it can drive an 8-bit pulse-width-modulated level. That level is compared against the counter low byte, and its threshold is reloaded from the module's high byte each time the low byte wraps. Every flag is sticky until software writes it. The block raises one interrupt request for all flags whose enable bit is set.

Top module: `pca_array`

## Requirements
- R1: After reset the counter, all flags, the capture registers, cex_o and irq_o are zero.
- R2: The clock select in mode bits [2:1] picks the count step: 00 is one step every 6 clocks, 01 is one step every 2 clocks, 10 is one step per tmr_ovf_i pulse, and 11 is one step per falling edge of ext_cnt_i after a two-flop synchronizer.
- R3: The counter advances only while the run bit ctrl[6] is 1. While mode bit 7 (idle stop) and idle_i are both 1, it holds its value.
- R4: A step from FFFFh to 0000h sets the overflow flag ctrl[7]. The flag stays set until a ctrl write loads 0. irq_o is 1 whenever this flag and mode bit 0 are both 1.
- R5: Module configuration bits are: 6 compare enable, 5 rising capture, 4 falling capture, 3 match, 2 toggle, 1 PWM, 0 interrupt enable. A module raises irq_o when its flag and its bit 0 are both set.
- R6: A synchronized rising edge on cex_i (with bit 5) or a falling edge (with bit 4) copies the counter into the module's capture register and sets its flag. An edge of the unselected polarity changes neither.
- R7: With bits 6 and 3 set, the counter stepping onto the module's 16-bit value sets its flag, which ctrl bit n clears.
- R8: With bits 6, 3 and 2 set, cex_o of the module inverts on every such match and otherwise keeps its level.
- R9: With bits 6 and 1 set, cex_o is 1 exactly when the counter low byte is greater than or equal to the module's low byte. The low byte is reloaded from the high byte on each step from low byte FFh to 00h.
- R10: A write to a module's low compare byte clears its compare enable, and a write to its high byte sets it again.
- R11: cnt_lo_we_i and cnt_hi_we_i load the counter bytes from wdata_i. A write takes priority over a step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idle_i | input | 1 | Chip idle status |
| tmr_ovf_i | input | 1 | One-cycle timer overflow pulse |
| ext_cnt_i | input | 1 | External count input, asynchronous |
| cex_i | input | NUM_MOD | Module pins as inputs, asynchronous |
| wdata_i | input | 8 | Write data shared by all write strobes |
| mode_we_i | input | 1 | Write mode register (idle stop, clock select, overflow irq enable) |
| ctrl_we_i | input | 1 | Write control register (overflow flag, run, module flags) |
| cnt_lo_we_i | input | 1 | Write counter low byte |
| cnt_hi_we_i | input | 1 | Write counter high byte |
| cfg_we_i | input | NUM_MOD | Write module configuration |
| cap_lo_we_i | input | NUM_MOD | Write module low compare/capture byte |
| cap_hi_we_i | input | NUM_MOD | Write module high compare/capture byte |
| cex_o | output | NUM_MOD | Module pin output levels |
| ovf_flag_o | output | 1 | Counter overflow flag |
| mod_flag_o | output | NUM_MOD | Module event flags |
| irq_o | output | 1 | Combined interrupt request |
| cnt_o | output | 16 | Counter value |
| cap_o | output | 16*NUM_MOD | Module compare/capture registers |

## Verification
On every cycle, the assertions check the following. A step increments the counter by one. A stopped or idle-held counter stays stable. A wrap sets the overflow flag. Each match or capture event sets the module flag, and a capture holds the counter value seen at that edge. A toggle-mode match inverts the pin. A low byte wrap in PWM mode reloads the threshold, and a low byte write drops the compare enable. Only the bench scenarios can show the following. Each clock select has its exact step rate over a window. An edge of the wrong polarity has no effect. A disarmed compare really misses its match. The PWM level is correct across the whole low byte range after a reload.

// File: rtl/pca_pkg.sv
package pca_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SEL_DIV_SLOW = 2'b00,
    SEL_DIV_FAST = 2'b01,
    SEL_TMR_OVF  = 2'b10,
    SEL_EXT      = 2'b11
  } clk_sel_e;

  typedef struct packed {
    logic rsv;
    logic cmp_en;
    logic cap_pos;
    logic cap_neg;
    logic match_en;
    logic toggle_en;
    logic pwm_en;
    logic irq_en;
  } mod_cfg_t;
endpackage

// File: rtl/pca_sync.sv
module pca_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], in_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/pca_timebase.sv
module pca_timebase
  import pca_pkg::*;
#(
  parameter int DIV_SLOW = 6,
  parameter int DIV_FAST = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  clk_sel_e         sel_i,
  input  logic             run_i,
  input  logic             hold_i,
  input  logic             tmr_ovf_i,
  input  logic             ext_fall_i,
  input  logic             lo_we_i,
  input  logic             hi_we_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic             flag_we_i,
  input  logic             flag_wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             inc_o,
  output logic             ovf_flag_o
);
  localparam int SLOW_W = (DIV_SLOW > 1) ? $clog2(DIV_SLOW) : 1;
  localparam int FAST_W = (DIV_FAST > 1) ? $clog2(DIV_FAST) : 1;
  localparam logic [SLOW_W-1:0] SLOW_LAST = SLOW_W'(DIV_SLOW - 1);
  localparam logic [FAST_W-1:0] FAST_LAST = FAST_W'(DIV_FAST - 1);

  logic [SLOW_W-1:0] slow_q;
  logic [FAST_W-1:0] fast_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              flag_q;
  logic              src_tick, wr_any, wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slow_q <= '0;
      fast_q <= '0;
    end else begin
      slow_q <= (slow_q == SLOW_LAST) ? '0 : slow_q + 1'b1;
      fast_q <= (fast_q == FAST_LAST) ? '0 : fast_q + 1'b1;
    end
  end

  always_comb begin
    unique case (sel_i)
      SEL_DIV_SLOW: src_tick = (slow_q == SLOW_LAST);
      SEL_DIV_FAST: src_tick = (fast_q == FAST_LAST);
      SEL_TMR_OVF:  src_tick = tmr_ovf_i;
      default:      src_tick = ext_fall_i;
    endcase
  end

  assign wr_any    = lo_we_i | hi_we_i;
  assign inc_o     = run_i & ~hold_i & src_tick & ~wr_any;
  assign cnt_nxt_o = cnt_q + 1'b1;
  assign wrap      = inc_o & (cnt_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (inc_o) cnt_q <= cnt_nxt_o;
      if (lo_we_i) cnt_q[BYTE_W-1:0] <= wdata_i;
      if (hi_we_i) cnt_q[CNT_W-1:BYTE_W] <= wdata_i;
      flag_q <= (flag_we_i ? flag_wdata_i : flag_q) | wrap;
    end
  end

  assign cnt_o      = cnt_q;
  assign ovf_flag_o = flag_q;

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_o |=> cnt_q == $past(cnt_q) + 1'b1);
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((hold_i || !run_i) && !wr_any) |=> $stable(cnt_q));
  p_wrap_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_o && cnt_q == '1) |=> (flag_q && cnt_q == '0));
endmodule

// File: rtl/pca_module.sv
module pca_module
  import pca_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  cnt_nxt_i,
  input  logic              inc_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              cfg_we_i,
  input  logic              lo_we_i,
  input  logic              hi_we_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              flag_we_i,
  input  logic              flag_wdata_i,
  output logic [CNT_W-1:0]  cap_o,
  output logic              flag_o,
  output logic              cex_o,
  output logic              irq_o
);
  mod_cfg_t         cfg_q;
  logic [CNT_W-1:0] cap_q;
  logic             flag_q, tog_q;
  logic             pwm_mode, match_ev, cap_ev, reload;

  assign pwm_mode = cfg_q.cmp_en & cfg_q.pwm_en;
  assign match_ev = inc_i & cfg_q.cmp_en & cfg_q.match_en & ~cfg_q.pwm_en
                  & (cnt_nxt_i == cap_q);
  assign cap_ev   = (cfg_q.cap_pos & rise_i) | (cfg_q.cap_neg & fall_i);
  assign reload   = pwm_mode & inc_i & (cnt_i[BYTE_W-1:0] == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      cap_q  <= '0;
      flag_q <= 1'b0;
      tog_q  <= 1'b0;
    end else begin
      if (cfg_we_i) cfg_q <= mod_cfg_t'(wdata_i);
      // arm/disarm around a two-byte compare update
      if (lo_we_i) cfg_q.cmp_en <= 1'b0;
      if (hi_we_i) cfg_q.cmp_en <= 1'b1;

      if (cap_ev) cap_q <= cnt_i;
      if (reload) cap_q[BYTE_W-1:0] <= cap_q[CNT_W-1:BYTE_W];
      if (lo_we_i) cap_q[BYTE_W-1:0] <= wdata_i;
      if (hi_we_i) cap_q[CNT_W-1:BYTE_W] <= wdata_i;

      flag_q <= (flag_we_i ? flag_wdata_i : flag_q) | match_ev | cap_ev;
      if (match_ev && cfg_q.toggle_en) tog_q <= ~tog_q;
    end
  end

  assign cex_o  = pwm_mode ? (cnt_i[BYTE_W-1:0] >= cap_q[BYTE_W-1:0]) : tog_q;
  assign cap_o  = cap_q;
  assign flag_o = flag_q;
  assign irq_o  = flag_q & cfg_q.irq_en;

  p_capture_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_ev && !lo_we_i && !hi_we_i) |=> (flag_q && cap_q == $past(cnt_i)));
  p_match_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_ev |=> flag_q);
  p_toggle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_ev && cfg_q.toggle_en) |=> tog_q != $past(tog_q));
  p_reload_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reload && !lo_we_i) |=> cap_q[BYTE_W-1:0] == $past(cap_q[CNT_W-1:BYTE_W]));
  p_disarm_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_we_i && !hi_we_i) |=> !cfg_q.cmp_en);
endmodule

// File: rtl/pca_array.sv
module pca_array
  import pca_pkg::*;
#(
  parameter int NUM_MOD  = 2,
  parameter int DIV_SLOW = 6,
  parameter int DIV_FAST = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     idle_i,
  input  logic                     tmr_ovf_i,
  input  logic                     ext_cnt_i,
  input  logic [NUM_MOD-1:0]       cex_i,
  input  logic [7:0]               wdata_i,
  input  logic                     mode_we_i,
  input  logic                     ctrl_we_i,
  input  logic                     cnt_lo_we_i,
  input  logic                     cnt_hi_we_i,
  input  logic [NUM_MOD-1:0]       cfg_we_i,
  input  logic [NUM_MOD-1:0]       cap_lo_we_i,
  input  logic [NUM_MOD-1:0]       cap_hi_we_i,
  output logic [NUM_MOD-1:0]       cex_o,
  output logic                     ovf_flag_o,
  output logic [NUM_MOD-1:0]       mod_flag_o,
  output logic                     irq_o,
  output logic [15:0]              cnt_o,
  output logic [16*NUM_MOD-1:0]    cap_o
);
  localparam int RUN_BIT  = 6;
  localparam int OVF_BIT  = 7;
  localparam int IDLE_BIT = 7;

  logic             idle_stop_q, ovf_ie_q, run_q;
  clk_sel_e         sel_q;
  logic             ext_fall, ext_rise_unused;
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             inc, ovf_flag;
  logic [NUM_MOD-1:0] cex_rise, cex_fall, mod_irq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_stop_q <= 1'b0;
      sel_q       <= SEL_DIV_SLOW;
      ovf_ie_q    <= 1'b0;
      run_q       <= 1'b0;
    end else begin
      if (mode_we_i) begin
        idle_stop_q <= wdata_i[IDLE_BIT];
        sel_q       <= clk_sel_e'(wdata_i[2:1]);
        ovf_ie_q    <= wdata_i[0];
      end
      if (ctrl_we_i) run_q <= wdata_i[RUN_BIT];
    end
  end

  pca_sync #(.STAGES(2)) u_ext_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   (ext_cnt_i),
    .rise_o (ext_rise_unused),
    .fall_o (ext_fall)
  );

  pca_timebase #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_timebase (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sel_i        (sel_q),
    .run_i        (run_q),
    .hold_i       (idle_stop_q & idle_i),
    .tmr_ovf_i    (tmr_ovf_i),
    .ext_fall_i   (ext_fall),
    .lo_we_i      (cnt_lo_we_i),
    .hi_we_i      (cnt_hi_we_i),
    .wdata_i      (wdata_i),
    .flag_we_i    (ctrl_we_i),
    .flag_wdata_i (wdata_i[OVF_BIT]),
    .cnt_o        (cnt),
    .cnt_nxt_o    (cnt_nxt),
    .inc_o        (inc),
    .ovf_flag_o   (ovf_flag)
  );

  for (genvar m = 0; m < NUM_MOD; m++) begin : g_mod
    pca_sync #(.STAGES(2)) u_cex_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .in_i   (cex_i[m]),
      .rise_o (cex_rise[m]),
      .fall_o (cex_fall[m])
    );

    pca_module u_mod (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .cnt_i        (cnt),
      .cnt_nxt_i    (cnt_nxt),
      .inc_i        (inc),
      .rise_i       (cex_rise[m]),
      .fall_i       (cex_fall[m]),
      .cfg_we_i     (cfg_we_i[m]),
      .lo_we_i      (cap_lo_we_i[m]),
      .hi_we_i      (cap_hi_we_i[m]),
      .wdata_i      (wdata_i),
      .flag_we_i    (ctrl_we_i),
      .flag_wdata_i (wdata_i[m]),
      .cap_o        (cap_o[m*16 +: 16]),
      .flag_o       (mod_flag_o[m]),
      .cex_o        (cex_o[m]),
      .irq_o        (mod_irq[m])
    );
  end

  assign cnt_o      = cnt;
  assign ovf_flag_o = ovf_flag;
  assign irq_o      = (ovf_flag & ovf_ie_q) | (|mod_irq);

  p_ovf_irq_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_flag && ovf_ie_q) |-> irq_o);
  p_quiet_irq_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ovf_flag && mod_flag_o == '0) |-> !irq_o);
endmodule

// File: tb/pca_array_tb.sv
module pca_array_tb;
  localparam int N = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic idle = 1'b0, tmr_ovf = 1'b0, ext_cnt = 1'b0;
  logic [N-1:0] cex_in = '0;
  logic [7:0] wdata = '0;
  logic mode_we = 1'b0, ctrl_we = 1'b0, cnt_lo_we = 1'b0, cnt_hi_we = 1'b0;
  logic [N-1:0] cfg_we = '0, cap_lo_we = '0, cap_hi_we = '0;
  logic [N-1:0] cex_out, mod_flag;
  logic ovf_flag, irq;
  logic [15:0] cnt;
  logic [16*N-1:0] cap;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pca_array #(.NUM_MOD(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .idle_i(idle), .tmr_ovf_i(tmr_ovf),
    .ext_cnt_i(ext_cnt), .cex_i(cex_in), .wdata_i(wdata),
    .mode_we_i(mode_we), .ctrl_we_i(ctrl_we), .cnt_lo_we_i(cnt_lo_we),
    .cnt_hi_we_i(cnt_hi_we), .cfg_we_i(cfg_we), .cap_lo_we_i(cap_lo_we),
    .cap_hi_we_i(cap_hi_we), .cex_o(cex_out), .ovf_flag_o(ovf_flag),
    .mod_flag_o(mod_flag), .irq_o(irq), .cnt_o(cnt), .cap_o(cap)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_mode(input logic [7:0] d);
    wdata = d; mode_we = 1'b1; @(negedge clk); mode_we = 1'b0;
  endtask
  task automatic wr_ctrl(input logic [7:0] d);
    wdata = d; ctrl_we = 1'b1; @(negedge clk); ctrl_we = 1'b0;
  endtask
  task automatic wr_cnt(input logic [15:0] v);
    wdata = v[7:0];  cnt_lo_we = 1'b1; @(negedge clk); cnt_lo_we = 1'b0;
    wdata = v[15:8]; cnt_hi_we = 1'b1; @(negedge clk); cnt_hi_we = 1'b0;
  endtask
  task automatic wr_cnt_lo(input logic [7:0] v);
    wdata = v; cnt_lo_we = 1'b1; @(negedge clk); cnt_lo_we = 1'b0;
  endtask
  task automatic wr_cfg(input int m, input logic [7:0] d);
    wdata = d; cfg_we[m] = 1'b1; @(negedge clk); cfg_we[m] = 1'b0;
  endtask
  task automatic wr_cap_lo(input int m, input logic [7:0] d);
    wdata = d; cap_lo_we[m] = 1'b1; @(negedge clk); cap_lo_we[m] = 1'b0;
  endtask
  task automatic wr_cap_hi(input int m, input logic [7:0] d);
    wdata = d; cap_hi_we[m] = 1'b1; @(negedge clk); cap_hi_we[m] = 1'b0;
  endtask
  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      tmr_ovf = 1'b1; @(negedge clk); tmr_ovf = 1'b0; @(negedge clk);
    end
  endtask
  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] c0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    // R1 reset state
    check("R1 cnt", cnt, 0);
    check("R1 flags", {ovf_flag, mod_flag}, 0);
    check("R1 cex", cex_out, 0);
    check("R1 irq", irq, 0);
    check("R1 cap", cap, 0);

    // R2 timer-overflow source, R3 run
    wr_mode(8'h04);
    wr_ctrl(8'h40);
    pulse(5);
    check("R2 tmr_ovf steps", cnt, 16'd5);

    // R11 counter load, R4 wrap
    wr_cnt(16'hFFFE);
    check("R11 counter load", cnt, 16'hFFFE);
    pulse(1);
    check("R4 before wrap", {ovf_flag, cnt}, {1'b0, 16'hFFFF});
    pulse(1);
    check("R4 wrap sets flag", {ovf_flag, cnt}, {1'b1, 16'h0000});
    check("R4 no irq without enable", irq, 0);
    wr_mode(8'h05);
    check("R4 irq with enable", irq, 1);
    pulse(2);
    check("R4 flag sticky", ovf_flag, 1);
    wr_ctrl(8'h40);
    check("R4 flag cleared", {ovf_flag, irq}, 0);

    // R3 idle stop and run bit
    wr_mode(8'h84);
    wr_cnt(16'h0100);
    idle = 1'b1;
    pulse(3);
    check("R3 idle hold", cnt, 16'h0100);
    idle = 1'b0;
    pulse(1);
    check("R3 idle release", cnt, 16'h0101);
    wr_mode(8'h04);
    idle = 1'b1;
    pulse(1);
    check("R3 idle ignored without stop bit", cnt, 16'h0102);
    idle = 1'b0;
    wr_ctrl(8'h00);
    pulse(2);
    check("R3 stopped", cnt, 16'h0102);

    // R2 divided clocks
    wr_ctrl(8'h40);
    wr_mode(8'h00);
    c0 = cnt; wait_n(60);
    check("R2 div6 rate", 16'(cnt - c0), 16'd10);
    wr_mode(8'h02);
    c0 = cnt; wait_n(40);
    check("R2 div2 rate", 16'(cnt - c0), 16'd20);

    // R2 external falling edges
    wr_mode(8'h06);
    wait_n(4);
    c0 = cnt;
    for (int i = 0; i < 7; i++) begin
      ext_cnt = 1'b1; wait_n(4); ext_cnt = 1'b0; wait_n(4);
    end
    check("R2 ext falling edges", 16'(cnt - c0), 16'd7);

    // R6 capture, counter frozen on tmr_ovf source without pulses
    wr_mode(8'h04);
    wr_cnt(16'h1234);
    wr_cfg(0, 8'h21);
    cex_in[0] = 1'b1; wait_n(5);
    check("R6 rising capture", cap[15:0], 16'h1234);
    check("R6 capture flag", mod_flag, 2'b01);
    check("R5 module irq", irq, 1);
    wr_ctrl(8'h40);
    wr_cnt(16'h2222);
    cex_in[0] = 1'b0; wait_n(5);
    check("R6 falling ignored", {mod_flag[0], cap[15:0]}, {1'b0, 16'h1234});
    wr_cfg(0, 8'h10);
    wr_cnt(16'h3333);
    cex_in[0] = 1'b1; wait_n(5);
    check("R6 rising ignored", {mod_flag[0], cap[15:0]}, {1'b0, 16'h1234});
    cex_in[0] = 1'b0; wait_n(5);
    check("R6 falling capture", {mod_flag[0], cap[15:0]}, {1'b1, 16'h3333});
    check("R5 irq enable off", irq, 0);
    wr_ctrl(8'h40);
    wr_cfg(0, 8'h30);
    wr_cnt(16'h4444);
    cex_in[0] = 1'b1; wait_n(5);
    check("R6 both edges rise", cap[15:0], 16'h4444);
    wr_cnt(16'h5555);
    cex_in[0] = 1'b0; wait_n(5);
    check("R6 both edges fall", cap[15:0], 16'h5555);
    wr_cfg(0, 8'h00);
    wr_ctrl(8'h40);

    // R10 disarm on low byte write, R7 match
    wr_cfg(1, 8'h48);
    wr_cap_lo(1, 8'h05);
    wr_cnt(16'h0000);
    pulse(6);
    check("R10 low write disarms", mod_flag[1], 0);
    wr_cap_hi(1, 8'h00);
    wr_cnt(16'h0000);
    pulse(4);
    check("R7 no match yet", mod_flag[1], 0);
    pulse(1);
    check("R7 match flag", {mod_flag[1], cnt}, {1'b1, 16'h0005});
    check("R7 no irq without enable", irq, 0);
    wr_cfg(1, 8'h49);
    check("R5 match irq", irq, 1);
    wr_ctrl(8'h40);
    check("R7 flag cleared", {mod_flag[1], irq}, 0);

    // R8 toggle
    wr_cfg(1, 8'h4C);
    check("R8 initial level", cex_out[1], 0);
    wr_cnt(16'h0000);
    pulse(5);
    check("R8 first toggle", cex_out[1], 1);
    wr_cnt(16'h0000);
    pulse(4);
    check("R8 holds between matches", cex_out[1], 1);
    pulse(1);
    check("R8 second toggle", cex_out[1], 0);
    wr_cfg(1, 8'h00);

    // R9 PWM
    wr_cfg(0, 8'h42);
    wr_cap_lo(0, 8'h40);
    wr_cap_hi(0, 8'h80);
    wr_cnt(16'h0010);
    check("R9 below threshold", cex_out[0], 0);
    wr_cnt_lo(8'h40);
    check("R9 at threshold", cex_out[0], 1);
    wr_cnt_lo(8'hFF);
    pulse(1);
    check("R9 reload on wrap", cap[7:0], 8'h80);
    check("R9 low after wrap", {cnt, cex_out[0]}, {16'h0100, 1'b0});
    for (int x = 0; x < 256; x++) begin
      wr_cnt_lo(8'(x));
      check("R9 pwm sweep", cex_out[0], (x >= 8'h80) ? 1 : 0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule